// File: doc/BRIEF.md
# Transmit byte FIFO with low-water trigger

This block is the transmit queue of a serial controller. It holds up to 16 bytes. Two kinds of writer can push bytes into it: a processor register write, or a DMA-style writer that marks its push as such. The serializer side gives one frame tick per transmitted frame. On each tick, while transmit is enabled and data is waiting, the block removes the oldest byte. That byte appears for one cycle either on the line-side output strobe or, when loopback is selected, on a strobe that feeds the receive queue.

Two status flags track the queue. The empty-trigger flag reports that the fill has dropped to a selectable low-water level. The end flag reports that the queue has drained. The transmit interrupt is a level taken from the empty-trigger flag and its enable. Software may write zeros to the flags to clear them, but a flag whose condition still holds stays set. Only DMA-style pushes clear the flags on their own. Reset and the flush control both leave the queue empty with both flags set.

Top module: `tx_byte_fifo`

## Requirements
- R1: While reset is held and after it is released, `fill` is 0 and both `tdfe` and `tend` are 1.
- R2: Bytes leave in the order they were accepted. `fill` counts the bytes held. An accepted push and a pop in the same cycle leave `fill` unchanged.
- R3: A pop happens only on a cycle with `frame_tick` high, `tx_en` high and `fill` non-zero. Otherwise `fill` and the outputs are unaffected by the tick.
- R4: A push while `fill` is 16 is dropped without effect. This holds even if a pop happens in the same cycle.
- R5: The low-water level is 8 >> `trig_sel`, so the encodings 0, 1, 2 and 3 give 8, 4, 2 and 1. After a pop, `tdfe` is set if the new fill is at or below the level, and `tend` is set if the new fill is 0.
- R6: A push with `push_dma` low never changes `tdfe` or `tend`.
- R7: A push with `push_dma` high clears both `tdfe` and `tend` when the fill after it exceeds the level.
- R8: A status write (`stat_wr`) with a 0 in `stat_tdfe` clears `tdfe` only when the new fill is above the level. A 0 in `stat_tend` clears `tend` only when the new fill is non-zero. A 1 in either field leaves that flag as it was.
- R9: `fifo_flush` empties the queue and sets both flags. In that cycle it overrides any push, pop or status write.
- R10: A popped byte drives `tx_valid`/`tx_data` when `loopback` is low. When `loopback` is high, the byte drives `lb_valid` (with the same data) only if `rx_en` is high; otherwise the byte is consumed and nothing is strobed.
- R11: `tx_irq` equals `tdfe` AND `tx_irq_en` at all times. Dropping the enable removes it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Push request |
| push_dma | input | 1 | Marks the push as DMA-style |
| push_data | input | 8 | Byte to push |
| frame_tick | input | 1 | One pulse per frame time |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable (gates loopback delivery) |
| loopback | input | 1 | Route popped bytes to the receive side |
| trig_sel | input | 2 | Low-water level select |
| fifo_flush | input | 1 | Empty the queue |
| stat_wr | input | 1 | Status write strobe |
| stat_tdfe | input | 1 | Written value for the empty-trigger flag |
| stat_tend | input | 1 | Written value for the end flag |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| fill | output | 5 | Bytes held |
| tdfe | output | 1 | Empty-trigger flag |
| tend | output | 1 | Transmit-end flag |
| tx_irq | output | 1 | Transmit interrupt level |
| tx_valid | output | 1 | Byte strobe to line side |
| tx_data | output | 8 | Popped byte |
| lb_valid | output | 1 | Byte strobe to receive side |

## Verification
`fill`, both flags and the two strobes are registered. Each is due in the first cycle after the clock edge that samples the stimulus. `tx_irq` is combinational from the flag register and the enable, so it is due in the same cycle as its inputs. The bench applies its inputs on the falling edge and lets one rising edge pass. It then compares every output against its own queue model on the next falling edge, so each registered result is checked exactly one edge after its cause. The sweeps cover every trigger setting with both push kinds. They fill past capacity, apply guarded status writes, and drain past empty.

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_dma,
  input  logic [DW-1:0] push_data,
  input  logic          frame_tick,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          loopback,
  input  logic [1:0]    trig_sel,
  input  logic          fifo_flush,
  input  logic          stat_wr,
  input  logic          stat_tdfe,
  input  logic          stat_tend,
  input  logic          tx_irq_en,
  output logic [CW-1:0] fill,
  output logic          tdfe,
  output logic          tend,
  output logic          tx_irq,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          lb_valid
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_n, trig;
  logic pop, push_ok, tdfe_n, tend_n;

  assign trig    = CW'(8) >> trig_sel;
  assign pop     = frame_tick & tx_en & (fill != '0) & ~fifo_flush;
  assign push_ok = push & (fill != CW'(DEPTH)) & ~fifo_flush;
  assign cnt_n   = fill + CW'(push_ok) - CW'(pop);
  assign tx_irq  = tdfe & tx_irq_en;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    tdfe_n = tdfe;
    tend_n = tend;
    if (stat_wr) begin
      tdfe_n = tdfe_n & stat_tdfe;
      tend_n = tend_n & stat_tend;
    end
    if (pop) begin
      if (cnt_n <= trig) tdfe_n = 1'b1;
      if (cnt_n == '0)   tend_n = 1'b1;
    end
    if (push_ok && push_dma && cnt_n > trig) begin
      tdfe_n = 1'b0;
      tend_n = 1'b0;
    end
    if (stat_wr) begin
      if (cnt_n <= trig) tdfe_n = 1'b1;
      if (cnt_n == '0)   tend_n = 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push_ok) mem[wp] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_flush) begin
      wp       <= '0;
      rp       <= '0;
      fill     <= '0;
      tdfe     <= 1'b1;
      tend     <= 1'b1;
      tx_valid <= 1'b0;
      lb_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      fill     <= cnt_n;
      tdfe     <= tdfe_n;
      tend     <= tend_n;
      tx_valid <= pop & ~loopback;
      lb_valid <= pop & loopback & rx_en;
      if (push_ok) wp <= wrap_inc(wp);
      if (pop) begin
        rp      <= wrap_inc(rp);
        tx_data <= mem[rp];
      end
    end
  end

endmodule

module tx_byte_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          frame_tick,
  input logic          tx_en,
  input logic          loopback,
  input logic [1:0]    trig_sel,
  input logic          fifo_flush,
  input logic          tx_irq_en,
  input logic [CW-1:0] fill,
  input logic          tdfe,
  input logic          tend,
  input logic          tx_irq,
  input logic          tx_valid
);

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fill == CW'(DEPTH) && !(frame_tick && tx_en) && !fifo_flush) |=> fill == CW'(DEPTH));

  // R9
  flush_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (fill == '0 && tdfe && tend));

  // R8
  tdfe_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tdfe) |-> fill > (CW'(8) >> $past(trig_sel)));

  // R8
  tend_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tend) |-> fill != '0);

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_irq_en |-> !tx_irq);

  // R10
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(frame_tick && tx_en && !loopback && fill != '0 && !fifo_flush));

endmodule

bind tx_byte_fifo tx_byte_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .frame_tick(frame_tick), .tx_en(tx_en),
  .loopback(loopback), .trig_sel(trig_sel), .fifo_flush(fifo_flush),
  .tx_irq_en(tx_irq_en), .fill(fill), .tdfe(tdfe), .tend(tend),
  .tx_irq(tx_irq), .tx_valid(tx_valid)
);

// File: tb/tb_tx_byte_fifo.sv
`timescale 1ns/1ps
module tb_tx_byte_fifo;
  logic clk = 0, rst_n = 0;
  logic push = 0, push_dma = 0, frame_tick = 0, tx_en = 0, rx_en = 0, loopback = 0;
  logic fifo_flush = 0, stat_wr = 0, stat_tdfe = 1, stat_tend = 1, tx_irq_en = 0;
  logic [7:0] push_data = 0;
  logic [1:0] trig_sel = 0;
  logic [4:0] fill;
  logic tdfe, tend, tx_irq, tx_valid, lb_valid;
  logic [7:0] tx_data;

  int errors = 0, checks = 0;
  int q[$];
  bit m_tdfe = 1, m_tend = 1;

  always #4 clk = ~clk;

  tx_byte_fifo dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    finish_run();
  end

  task automatic quiet();
    push = 0; push_dma = 0; frame_tick = 0; fifo_flush = 0; stat_wr = 0;
    stat_tdfe = 1; stat_tend = 1;
  endtask

  // one cycle: inputs already set at negedge; update model; check on next negedge
  task automatic cyc();
    int pre, n, trg, popped;
    bit pop, pok, exp_tx, exp_lb;
    pre = q.size();
    trg = 8 >> trig_sel;
    pop = frame_tick && tx_en && pre > 0 && !fifo_flush;
    pok = push && pre < 16 && !fifo_flush;
    exp_tx = 0; exp_lb = 0; popped = 0;
    @(posedge clk);
    if (fifo_flush) begin
      q.delete(); m_tdfe = 1; m_tend = 1;
    end else begin
      if (pop) popped = q.pop_front();
      if (pok) q.push_back(int'(push_data));
      n = q.size();
      if (stat_wr) begin m_tdfe &= stat_tdfe; m_tend &= stat_tend; end
      if (pop) begin if (n <= trg) m_tdfe = 1; if (n == 0) m_tend = 1; end
      if (pok && push_dma && n > trg) begin m_tdfe = 0; m_tend = 0; end
      if (stat_wr) begin if (n <= trg) m_tdfe = 1; if (n == 0) m_tend = 1; end
      exp_tx = pop && !loopback;
      exp_lb = pop && loopback && rx_en;
    end
    @(negedge clk);
    chk(fill == q.size(), "R2", "fill", fill, q.size());
    chk(tdfe == m_tdfe, "R5/R7/R8", "tdfe", tdfe, m_tdfe);
    chk(tend == m_tend, "R5/R7/R8", "tend", tend, m_tend);
    chk(tx_irq == (m_tdfe && tx_irq_en), "R11", "tx_irq", tx_irq, m_tdfe && tx_irq_en);
    chk(tx_valid == exp_tx, "R10", "tx_valid", tx_valid, exp_tx);
    chk(lb_valid == exp_lb, "R10", "lb_valid", lb_valid, exp_lb);
    if (exp_tx || exp_lb) chk(tx_data == popped[7:0], "R2", "data", tx_data, popped);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(fill == 0 && tdfe && tend, "R1", "reset state", {fill, tdfe, tend}, 3);
    rst_n = 1;
    cyc();
    chk(fill == 0 && tdfe && tend, "R1", "after reset", {fill, tdfe, tend}, 3);

    for (int sel = 0; sel < 4; sel++) begin
      for (int d = 0; d < 2; d++) begin
        quiet(); trig_sel = 2'(sel); fifo_flush = 1; tx_irq_en = 1; tx_en = 0;
        loopback = (d == 1); rx_en = (sel[0] == 1'b0);
        cyc();                                   // R9
        // fill to capacity plus two dropped (R4), flags per R6/R7
        for (int i = 0; i < 18; i++) begin
          quiet(); push = 1; push_dma = d[0]; push_data = 8'(sel * 40 + d * 20 + i);
          frame_tick = (i == 17); // R3: tick ignored while tx_en low
          cyc();
        end
        // R8: zeros written while fill above level
        quiet(); stat_wr = 1; stat_tdfe = 0; stat_tend = 0; cyc();
        quiet(); tx_irq_en = 0; cyc();           // R11
        tx_irq_en = 1;
        // drain, with a status write of zeros each step (R8) and R5 on pops
        for (int i = 0; i < 18; i++) begin
          quiet(); tx_en = 1; frame_tick = (i % 3 != 2);
          stat_wr = (i % 2 == 0); stat_tdfe = 0; stat_tend = 0;
          cyc();
        end
        for (int i = 0; i < 17; i++) begin
          quiet(); tx_en = 1; frame_tick = 1; cyc();
        end
      end
    end

    // R2/R4: push and pop together, at full and in the middle
    quiet(); trig_sel = 1; loopback = 0; tx_en = 0; fifo_flush = 1; cyc();
    for (int i = 0; i < 16; i++) begin quiet(); push = 1; push_data = 8'(200 + i); cyc(); end
    quiet(); tx_en = 1; frame_tick = 1; push = 1; push_data = 8'hEE; cyc();
    quiet(); tx_en = 1; frame_tick = 1; push = 1; push_dma = 1; push_data = 8'hDD; cyc();
    // R9: flush beats push and pop
    quiet(); fifo_flush = 1; push = 1; frame_tick = 1; cyc();
    chk(fill == 0 && !tx_valid, "R9", "flush override", {fill, tx_valid}, 0);
    // R6 vs R7 with a dma push just at the level (no clear) then above it
    for (int i = 0; i < 6; i++) begin quiet(); push = 1; push_dma = 1; push_data = 8'(i); cyc(); end
    for (int i = 0; i < 6; i++) begin quiet(); tx_en = 1; frame_tick = 1; cyc(); end
    quiet(); finish_run();
  end
endmodule